// File: doc/BRIEF.md
# Debug Test Access Port Controller

This block is the serial front end of a debug port. It follows the standard sixteen-state machine that the TMS pin steers. It holds a 5-bit instruction register and drives TDO. When the selected instruction is the identification code, the block itself serves a 32-bit identification register as the data path. Every other instruction gets a one-bit bypass register.

The block brings out one strobe per scan phase for external data registers. There are capture, shift and update strobes for the data branch and for the instruction branch, each high for the whole time the machine is in that state. External registers act on the rising TCK edge while their strobe is high.

The block uses both clock edges. TMS and TDI are taken on the rising edge of TCK. TDO and its enable are launched on the falling edge. An active-low asynchronous reset returns the machine to Test-Logic-Reset and puts the identification instruction in the instruction register. It clears nothing else.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While trst_n is low, the outputs are as follows, at once and with no TCK edge needed. ir_out is 5'b00001 (the identification instruction). tdo_en is 0. All six strobes are 0.
- R2: Five rising TCK edges with tms=1 reach Test-Logic-Reset from any state. The next rising edge with tms=0 enters Run-Test/Idle, and at that point ir_out reads 5'b00001.
- R3: From Run-Test/Idle, the data branch follows this tms sequence: 1 to Select-DR, 0 to Capture-DR, 0 to Shift-DR, which holds while tms=0. Then 1 to Exit1-DR and 1 to Update-DR. Update-DR goes to Run-Test/Idle on tms=0 and to Select-DR on tms=1. capture_dr, shift_dr and update_dr are high exactly in their states.
- R4: The instruction branch mirrors the data branch. Select-DR with tms=1 goes to Select-IR, and Select-IR with tms=1 returns to Test-Logic-Reset. capture_ir, shift_ir and update_ir are high exactly in their states.
- R5: From Exit1, tms=0 enters Pause, which holds on tms=0. From Pause, tms=1 enters Exit2. Exit2 returns to Shift on tms=0 and goes to Update on tms=1. No strobe is high in Pause or Exit2, and a bit shifted before the pause is kept.
- R6: Capture-IR loads the status value 5'b00001 (the low two bits are fixed at 01). It leaves on TDO least significant bit first during Shift-IR.
- R7: The instruction shifted in (LSB first from TDI) appears on ir_out only on the rising edge that leaves Update-IR. ir_out holds its value through Shift-IR, Exit1-IR and Update-IR.
- R8: With instruction 5'b00001, Capture-DR loads the identification value 32'h3E5A7C4B (bit 0 set). It leaves on TDO least significant bit first.
- R9: With any instruction other than 5'b00001, including the bypass code 5'b11111, the data path is a one-bit register. It captures 0, and on TDO it repeats TDI delayed by one rising edge.
- R10: TDO changes only on falling TCK edges. tdo_en is 1 exactly between the falling edges that follow entry into Shift-DR or Shift-IR and exit from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset of the controller |
| tms | input | 1 | Mode select, taken on rising tck |
| tdi | input | 1 | Serial data in, taken on rising tck |
| tdo | output | 1 | Serial data out, launched on falling tck |
| tdo_en | output | 1 | Output enable for tdo |
| ir_out | output | 5 | Current instruction |
| capture_dr | output | 1 | High in Capture-DR |
| shift_dr | output | 1 | High in Shift-DR |
| update_dr | output | 1 | High in Update-DR |
| capture_ir | output | 1 | High in Capture-IR |
| shift_ir | output | 1 | High in Shift-IR |
| update_ir | output | 1 | High in Update-IR |

## Verification
Two things can meet on the same rising edge: the last shift of a scan and the state change out of Shift. That edge both moves a final bit into the shift path and leaves the shift state. The pause test exits Shift-DR while a 0 is on TDI, then re-enters Shift through Pause and Exit2, and expects that 0 on TDO. The same collision occurs in the instruction branch, where the final instruction bit is shifted on the edge that enters Exit1-IR. There ir_out is expected to stay unchanged until the edge that leaves Update-IR.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef struct packed {
    logic tlr;
    logic cap_dr;
    logic sh_dr;
    logic upd_dr;
    logic cap_ir;
    logic sh_ir;
    logic upd_ir;
  } tap_strobe_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic        tck,
  input  logic        trst_n,
  input  logic        tms,
  output tap_strobe_t strb
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= ST_TLR;
    else         state_q <= state_d;
  end

  always_comb begin
    strb.tlr    = (state_q == ST_TLR);
    strb.cap_dr = (state_q == ST_CAP_DR);
    strb.sh_dr  = (state_q == ST_SH_DR);
    strb.upd_dr = (state_q == ST_UPD_DR);
    strb.cap_ir = (state_q == ST_CAP_IR);
    strb.sh_ir  = (state_q == ST_SH_IR);
    strb.upd_ir = (state_q == ST_UPD_IR);
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir #(
  parameter int            W        = 5,
  parameter logic [W-1:0]  RST_CODE = 1,
  parameter logic [W-1:0]  STATUS   = 1
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tdi,
  input  logic         capture,
  input  logic         shift,
  input  logic         update,
  input  logic         tlr,
  output logic [W-1:0] ir_q,
  output logic         sh_lsb
);

  logic [W-1:0] sh_q;

  // Shift path is always loaded by Capture-IR before use; no reset needed.
  always_ff @(posedge tck) begin
    if (capture)    sh_q <= STATUS;
    else if (shift) sh_q <= {tdi, sh_q[W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     ir_q <= RST_CODE;
    else if (tlr)    ir_q <= RST_CODE;
    else if (update) ir_q <= sh_q;
  end

  assign sh_lsb = sh_q[0];

endmodule

// File: rtl/tap_dr_paths.sv
module tap_dr_paths #(
  parameter int              ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h3E5A7C4B
) (
  input  logic tck,
  input  logic tdi,
  input  logic sel_id,
  input  logic capture,
  input  logic shift,
  output logic dr_lsb
);

  logic [ID_W-1:0] id_q;
  logic            byp_q;

  // Data paths are untouched by the controller reset; capture defines them.
  always_ff @(posedge tck) begin
    if (sel_id) begin
      if (capture)    id_q <= ID_VAL;
      else if (shift) id_q <= {tdi, id_q[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (!sel_id) begin
      if (capture)    byp_q <= 1'b0;
      else if (shift) byp_q <= tdi;
    end
  end

  assign dr_lsb = sel_id ? id_q[0] : byp_q;

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import tap_pkg::*;
#(
  parameter int              IR_W   = 5,
  parameter int              ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h3E5A7C4B
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_en,
  output logic [IR_W-1:0] ir_out,
  output logic            capture_dr,
  output logic            shift_dr,
  output logic            update_dr,
  output logic            capture_ir,
  output logic            shift_ir,
  output logic            update_ir
);

  localparam logic [IR_W-1:0] IR_IDCODE = {{(IR_W-1){1'b0}}, 1'b1};
  localparam logic [IR_W-1:0] IR_STATUS = {{(IR_W-2){1'b0}}, 2'b01};

  tap_strobe_t strb;
  logic        in_tlr;
  logic        ir_lsb;
  logic        dr_lsb;
  logic        sel_id;

  tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .strb   (strb)
  );

  tap_ir #(
    .W        (IR_W),
    .RST_CODE (IR_IDCODE),
    .STATUS   (IR_STATUS)
  ) u_ir (
    .tck     (tck),
    .trst_n  (trst_n),
    .tdi     (tdi),
    .capture (strb.cap_ir),
    .shift   (strb.sh_ir),
    .update  (strb.upd_ir),
    .tlr     (strb.tlr),
    .ir_q    (ir_out),
    .sh_lsb  (ir_lsb)
  );

  assign sel_id = (ir_out == IR_IDCODE);

  tap_dr_paths #(
    .ID_W   (ID_W),
    .ID_VAL (ID_VAL)
  ) u_dr (
    .tck     (tck),
    .tdi     (tdi),
    .sel_id  (sel_id),
    .capture (strb.cap_dr),
    .shift   (strb.sh_dr),
    .dr_lsb  (dr_lsb)
  );

  // Output stage launched on the falling edge.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= strb.sh_dr | strb.sh_ir;
      if (strb.sh_ir)      tdo <= ir_lsb;
      else if (strb.sh_dr) tdo <= dr_lsb;
    end
  end

  assign in_tlr     = strb.tlr;
  assign capture_dr = strb.cap_dr;
  assign shift_dr   = strb.sh_dr;
  assign update_dr  = strb.upd_dr;
  assign capture_ir = strb.cap_ir;
  assign shift_ir   = strb.sh_ir;
  assign update_ir  = strb.upd_ir;

endmodule

// File: rtl/tap_checker.sv
module tap_checker #(
  parameter int IR_W = 5
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input logic            tdo_en,
  input logic [IR_W-1:0] ir_out,
  input logic            capture_dr,
  input logic            shift_dr,
  input logic            update_dr,
  input logic            capture_ir,
  input logic            shift_ir,
  input logic            update_ir,
  input logic            tlr
);

  localparam logic [IR_W-1:0] IDC = {{(IR_W-1){1'b0}}, 1'b1};

  p_tdo_en_window_r10: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (shift_dr || shift_ir));

  p_strobe_onehot_r3: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({capture_dr, shift_dr, update_dr, capture_ir, shift_ir, update_ir}));

  p_shift_hold_r3: assert property (@(posedge tck) disable iff (!trst_n)
    shift_dr && !tms |=> shift_dr);

  p_capture_to_shift_r4: assert property (@(posedge tck) disable iff (!trst_n)
    capture_ir && !tms |=> shift_ir);

  p_ir_stable_r7: assert property (@(posedge tck) disable iff (!trst_n)
    !update_ir && !tlr |=> $stable(ir_out));

  p_tlr_loads_id_r2: assert property (@(posedge tck) disable iff (!trst_n)
    tlr |=> ir_out == IDC);

endmodule

bind jtag_tap_ctrl tap_checker #(.IR_W(IR_W)) u_chk (
  .tck        (tck),
  .trst_n     (trst_n),
  .tms        (tms),
  .tdo_en     (tdo_en),
  .ir_out     (ir_out),
  .capture_dr (capture_dr),
  .shift_dr   (shift_dr),
  .update_dr  (update_dr),
  .capture_ir (capture_ir),
  .shift_ir   (shift_ir),
  .update_ir  (update_ir),
  .tlr        (in_tlr)
);

// File: tb/jtag_tap_ctrl_tb_top.sv
module jtag_tap_ctrl_tb_top;

  localparam int          CLK_PERIOD = 20;
  localparam logic [31:0] ID_EXP     = 32'h3E5A7C4B;
  localparam logic [4:0]  IDC        = 5'b00001;
  localparam logic [4:0]  BYP        = 5'b11111;
  localparam logic [4:0]  STAT       = 5'b00001;

  logic       tck, trst_n, tms, tdi;
  logic       tdo, tdo_en;
  logic [4:0] ir_out;
  logic       capture_dr, shift_dr, update_dr, capture_ir, shift_ir, update_ir;

  int total = 0;
  int bad   = 0;

  jtag_tap_ctrl dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_en(tdo_en), .ir_out(ir_out),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir)
  );

  initial begin
    tck = 1'b0;
    forever #(CLK_PERIOD/2) tck = ~tck;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] strobes();
    return {capture_dr, shift_dr, update_dr, capture_ir, shift_ir, update_ir};
  endfunction

  // Drive inputs, pass one rising and one falling edge, settle.
  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #2;
  endtask

  task automatic t_reset();
    trst_n = 1'b0;
    #3;
    chk("R1 ir_out in reset", 32'(ir_out), 32'(IDC));
    chk("R1 tdo_en in reset", 32'(tdo_en), 0);
    chk("R1 strobes in reset", 32'(strobes()), 0);
    @(negedge tck);
    #2;
    trst_n = 1'b1;
    tick(1'b0, 1'b0);
    chk("R2 tlr->rti strobes", 32'(strobes()), 0);
  endtask

  task automatic t_idcode();
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R3 capture_dr strobe", 32'(strobes()), 32'b100000);
    tick(1'b0, 1'b0);
    chk("R3 shift_dr strobe", 32'(strobes()), 32'b010000);
    chk("R10 tdo_en in shift", 32'(tdo_en), 1);
    for (int i = 0; i < 32; i++) begin
      chk($sformatf("R8 id bit %0d", i), 32'(tdo), 32'(ID_EXP[i]));
      tick(i == 31, 1'b0);
    end
    chk("R10 tdo_en after exit", 32'(tdo_en), 0);
    tick(1'b1, 1'b0);
    chk("R3 update_dr strobe", 32'(strobes()), 32'b001000);
    tick(1'b0, 1'b0);
    chk("R3 back to idle", 32'(strobes()), 0);
  endtask

  task automatic load_ir(input logic [4:0] code);
    logic [4:0] old;
    old = ir_out;
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R4 capture_ir strobe", 32'(strobes()), 32'b000100);
    tick(1'b0, 1'b0);
    chk("R4 shift_ir strobe", 32'(strobes()), 32'b000010);
    for (int i = 0; i < 5; i++) begin
      chk($sformatf("R6 status bit %0d", i), 32'(tdo), 32'(STAT[i]));
      tick(i == 4, code[i]);
      chk("R7 ir held while scanning", 32'(ir_out), 32'(old));
    end
    tick(1'b1, 1'b0);
    chk("R4 update_ir strobe", 32'(strobes()), 32'b000001);
    chk("R7 ir held in update", 32'(ir_out), 32'(old));
    tick(1'b0, 1'b0);
    chk("R7 ir takes new code", 32'(ir_out), 32'(code));
  endtask

  task automatic t_bypass(input logic [4:0] code);
    logic [7:0] pat;
    logic       prev;
    pat = 8'b1011_0010;
    load_ir(code);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    chk("R9 bypass captures 0", 32'(tdo), 0);
    for (int i = 0; i < 8; i++) begin
      prev = tdo;
      tms  = 1'b0;
      tdi  = pat[i];
      @(posedge tck);
      #1;
      chk("R10 tdo steady across rising edge", 32'(tdo), 32'(prev));
      @(negedge tck);
      #2;
      chk($sformatf("R9 bypass delay bit %0d", i), 32'(tdo), 32'(pat[i]));
    end
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic t_pause();
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    chk("R9 bypass passes 1", 32'(tdo), 1);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b1);
    chk("R5 pause no strobe", 32'(strobes()), 0);
    chk("R5 tdo_en low in pause", 32'(tdo_en), 0);
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b1);
    chk("R5 exit2 no strobe", 32'(strobes()), 0);
    tick(1'b0, 1'b1);
    chk("R5 exit2 back to shift", 32'(strobes()), 32'b010000);
    chk("R5 bit from exit edge kept", 32'(tdo), 0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    chk("R5 exit2 to update", 32'(strobes()), 32'b001000);
    tick(1'b0, 1'b0);
  endtask

  task automatic t_update_to_select();
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R3 update->select->capture", 32'(strobes()), 32'b100000);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic t_select_ir_tlr();
    load_ir(BYP);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R4 select_ir tms1 to reset", 32'(ir_out), 32'(IDC));
  endtask

  task automatic t_five_ones();
    load_ir(BYP);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R2 parked in pause-dr", 32'(ir_out), 32'(BYP));
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R2 five ones reset ir", 32'(ir_out), 32'(IDC));
    chk("R2 idle after reset", 32'(strobes()), 0);
  endtask

  task automatic t_async();
    load_ir(BYP);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    chk("R10 tdo_en before async", 32'(tdo_en), 1);
    trst_n = 1'b0;
    #1;
    chk("R1 async ir reload", 32'(ir_out), 32'(IDC));
    chk("R1 async tdo_en drop", 32'(tdo_en), 0);
    chk("R1 async strobes", 32'(strobes()), 0);
    @(negedge tck);
    #2;
    trst_n = 1'b1;
    tick(1'b0, 1'b0);
  endtask

  initial begin
    trst_n = 1'b0;
    tms    = 1'b1;
    tdi    = 1'b0;
    @(negedge tck);
    #2;
    t_reset();
    t_idcode();
    t_bypass(BYP);
    t_pause();
    t_bypass(5'b00110);
    t_update_to_select();
    t_select_ir_tlr();
    t_five_ones();
    t_async();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule